// File: doc/BRIEF.md
# Prioritized Interrupt Level Resolver

The resolver merges two sources of pending interrupts into one priority level and one summary vector. One source is a software-request register: its valid bits fold down to a compact range of low levels. The other is a set of external interrupt lines, each of which maps straight to the level equal to its bit index. When the two disagree, a pending external line always decides the level, whatever the software requests are.

Each evaluation strobe samples both sources. If the resolved level is nonzero and strictly above the current priority level, the block raises a one-cycle trap request. In the same clock edge it latches the summary vector and the level into its summary and interrupt-ID registers.

An evaluation consumes the block's arm. Later strobes are ignored until a return-from-exception pulse arms it again. The block comes out of reset armed. A pending asynchronous-trap request at evaluation time is not supported, so the block flags it on an error output.

Top module: `irq_level_resolver`

## Requirements
- R1: Software request bits 4 to 18 are valid. A set bit i gives level i-3, so bit 4 gives level 1 and bit 18 gives level 15. The highest set valid bit decides the software level.
- R2: External bits 20 to 30 are valid. A set bit i gives level i, and the highest set valid bit decides the external level.
- R3: When any valid external bit is set, the resolved level is the external level, even where a software level is also pending.
- R4: The summary vector has every valid pending bit of both sources set at its own bit position. Software bits outside 4..18 and external bits outside 20..30 affect neither the summary nor the level.
- R5: A trap is requested only when the resolved level is nonzero and strictly greater than the 5-bit current priority level. An equal or lower level gives no trap.
- R6: On a trap, trap_req is high for exactly the one cycle after the clock edge that sampled the evaluation. isr_q and intid_q take the summary and the level on that same edge.
- R7: An evaluation that does not trap leaves isr_q and intid_q unchanged.
- R8: The block is armed after reset. An evaluation taken while armed disarms it, whether or not it traps. A strobe while disarmed has no effect. A rfe pulse re-arms the block, and rfe takes precedence when it arrives in the same cycle as an evaluation.
- R9: When an armed evaluation sees a nonzero asynchronous-trap request, async_err is high for the following cycle.
- R10: While reset is asserted, trap_req, async_err, isr_q and intid_q are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req | input | 32 | Software interrupt request register |
| ext_irq | input | 32 | External interrupt status lines |
| cur_ipl | input | 5 | Current priority level |
| ast_req | input | 4 | Asynchronous-trap request bits |
| eval | input | 1 | Evaluate strobe |
| rfe | input | 1 | Return-from-exception pulse, re-arms evaluation |
| trap_req | output | 1 | Interrupt trap request, one-cycle pulse |
| async_err | output | 1 | Unsupported asynchronous-trap request seen |
| isr_q | output | 32 | Latched interrupt summary |
| intid_q | output | 5 | Latched interrupt ID (level) |

## Verification
The bench sets both sources at once to catch a design that lets software outrank external lines, or that keeps the lower bit instead of the highest in a group. It places the resolved level exactly equal to the current level, to expose a greater-or-equal compare. It drives bits just outside each valid range (3, 19, 31, 5), to expose leaky masks. It strobes again without a rfe, and checks that no trap follows and the latched values stay put. A design that never disarmed, or that rewrote the summary on a non-trapping evaluation, would show a second trap or changed registers.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  parameter int SUM_W  = 32;
  parameter int LVL_W  = 5;
  parameter int AST_W  = 4;
  parameter int SW_LO  = 4;
  parameter int SW_HI  = 18;
  parameter int EXT_LO = 20;
  parameter int EXT_HI = 30;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [SUM_W-1:0] sum_t;
endpackage

// File: rtl/irq_res_prio_enc.sv
module irq_res_prio_enc #(
  parameter int VEC_W = 32,
  parameter int LO    = 4,
  parameter int HI    = 18,
  parameter int BASE  = 1,
  parameter int LVL_W = 5
) (
  input  logic [VEC_W-1:0] req,
  output logic [LVL_W-1:0] lvl,
  output logic             hit,
  output logic [VEC_W-1:0] pend
);
  // only bits inside the window pass to the summary
  for (genvar g = 0; g < VEC_W; g++) begin : g_mask
    if (g >= LO && g <= HI) begin : g_in
      assign pend[g] = req[g];
    end else begin : g_out
      assign pend[g] = 1'b0;
    end
  end

  // ascending scan: the last set bit, i.e. the highest, wins
  always_comb begin
    lvl = '0;
    hit = 1'b0;
    for (int i = LO; i <= HI; i++) begin
      if (req[i]) begin
        lvl = LVL_W'(i - LO + BASE);
        hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_res_merge.sv
module irq_res_merge
  import irq_res_pkg::*;
(
  input  lvl_t sw_lvl,
  input  sum_t sw_pend,
  input  lvl_t ext_lvl,
  input  logic ext_hit,
  input  sum_t ext_pend,
  input  lvl_t cur_ipl,
  output lvl_t res_lvl,
  output sum_t res_sum,
  output logic take
);
  always_comb begin
    res_lvl = ext_hit ? ext_lvl : sw_lvl;
    res_sum = sw_pend | ext_pend;
    take    = (res_lvl != '0) && (res_lvl > cur_ipl);
  end
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irq_res_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUM_W-1:0] sw_req,
  input  logic [SUM_W-1:0] ext_irq,
  input  logic [LVL_W-1:0] cur_ipl,
  input  logic [AST_W-1:0] ast_req,
  input  logic             eval,
  input  logic             rfe,
  output logic             trap_req,
  output logic             async_err,
  output logic [SUM_W-1:0] isr_q,
  output logic [LVL_W-1:0] intid_q
);
  lvl_t sw_lvl, ext_lvl, res_lvl;
  logic sw_hit, ext_hit, take;
  sum_t sw_pend, ext_pend, res_sum;

  irq_res_prio_enc #(.VEC_W(SUM_W), .LO(SW_LO), .HI(SW_HI), .BASE(1), .LVL_W(LVL_W)) u_sw_enc (
    .req(sw_req), .lvl(sw_lvl), .hit(sw_hit), .pend(sw_pend)
  );

  irq_res_prio_enc #(.VEC_W(SUM_W), .LO(EXT_LO), .HI(EXT_HI), .BASE(EXT_LO), .LVL_W(LVL_W)) u_ext_enc (
    .req(ext_irq), .lvl(ext_lvl), .hit(ext_hit), .pend(ext_pend)
  );

  irq_res_merge u_merge (
    .sw_lvl(sw_lvl), .sw_pend(sw_pend), .ext_lvl(ext_lvl), .ext_hit(ext_hit),
    .ext_pend(ext_pend), .cur_ipl(cur_ipl), .res_lvl(res_lvl), .res_sum(res_sum),
    .take(take)
  );

  logic armed_q, armed_d;
  logic trap_d, err_d, fire;
  logic cap_en;
  sum_t isr_d;
  lvl_t intid_d;

  always_comb begin
    fire    = eval && armed_q;
    trap_d  = fire && take;
    err_d   = fire && (ast_req != '0);
    cap_en  = trap_d;
    isr_d   = cap_en ? res_sum : isr_q;
    intid_d = cap_en ? res_lvl : intid_q;
    if (rfe)       armed_d = 1'b1;
    else if (fire) armed_d = 1'b0;
    else           armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b1;
      trap_req  <= 1'b0;
      async_err <= 1'b0;
      isr_q     <= '0;
      intid_q   <= '0;
    end else begin
      armed_q   <= armed_d;
      trap_req  <= trap_d;
      async_err <= err_d;
      isr_q     <= isr_d;
      intid_q   <= intid_d;
    end
  end

  // R5
  trap_above_ipl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (intid_q > $past(cur_ipl)) && (intid_q != '0));
  // R6
  trap_from_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(eval));
  // R7
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> $stable(isr_q) && $stable(intid_q));
  // R9
  async_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    async_err |-> $past(eval) && ($past(ast_req) != '0));
  // R8
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && armed_q && !rfe) |=> !armed_q);
endmodule

// File: tb/test_irq_level_resolver.sv
module test_irq_level_resolver;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] sw_req, ext_irq;
  logic [4:0]  cur_ipl;
  logic [3:0]  ast_req;
  logic        eval, rfe;
  logic        trap_req, async_err;
  logic [31:0] isr_q;
  logic [4:0]  intid_q;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  irq_level_resolver i_irq_level_resolver (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .ext_irq(ext_irq),
    .cur_ipl(cur_ipl), .ast_req(ast_req), .eval(eval), .rfe(rfe),
    .trap_req(trap_req), .async_err(async_err), .isr_q(isr_q), .intid_q(intid_q)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_rfe();
    @(negedge clk); rfe = 1'b1;
    @(negedge clk); rfe = 1'b0;
  endtask

  // one armed evaluation; returns at the negedge after the sampling edge
  task automatic do_eval(input logic [31:0] s, input logic [31:0] e, input logic [4:0] ipl, input logic [3:0] a);
    @(negedge clk);
    sw_req = s; ext_irq = e; cur_ipl = ipl; ast_req = a; eval = 1'b1;
    @(negedge clk);
    eval = 1'b0;
  endtask

  task automatic t_reset();
    chk(trap_req == 0, "R10 trap", 32'(trap_req), 0);
    chk(async_err == 0, "R10 err", 32'(async_err), 0);
    chk(isr_q == 0, "R10 isr", isr_q, 0);
    chk(intid_q == 0, "R10 intid", 32'(intid_q), 0);
  endtask

  task automatic t_sw_only();
    do_eval(32'h0000_0210, 0, 5'd0, 0);   // bits 4 and 9 -> level 6
    chk(trap_req == 1, "R1 trap", 32'(trap_req), 1);
    chk(intid_q == 5'd6, "R1 level", 32'(intid_q), 6);
    chk(isr_q == 32'h0000_0210, "R4 summary", isr_q, 32'h210);
    @(negedge clk);
    chk(trap_req == 0, "R6 pulse one cycle", 32'(trap_req), 0);
  endtask

  task automatic t_disarmed();
    do_eval(32'h0004_0000, 32'h4000_0000, 5'd0, 0);
    chk(trap_req == 0, "R8 disarmed eval ignored", 32'(trap_req), 0);
    chk(isr_q == 32'h0000_0210, "R8 isr kept", isr_q, 32'h210);
    chk(intid_q == 5'd6, "R8 intid kept", 32'(intid_q), 6);
  endtask

  task automatic t_ext_override();
    do_rfe();
    do_eval(32'h0004_0000, 32'h0040_0000, 5'd10, 0);  // sw 18 (lvl 15), ext 22
    chk(trap_req == 1, "R3 trap", 32'(trap_req), 1);
    chk(intid_q == 5'd22, "R3 ext overrides", 32'(intid_q), 22);
    chk(isr_q == 32'h0044_0000, "R4 merged summary", isr_q, 32'h0044_0000);
  endtask

  task automatic t_ext_highest();
    do_rfe();
    do_eval(0, 32'h4010_0000, 5'd0, 0);  // bits 20 and 30
    chk(intid_q == 5'd30, "R2 highest ext", 32'(intid_q), 30);
  endtask

  task automatic t_equal_ipl();
    do_rfe();
    do_eval(0, 32'h0040_0000, 5'd22, 0);
    chk(trap_req == 0, "R5 equal no trap", 32'(trap_req), 0);
    chk(intid_q == 5'd30, "R7 intid unchanged", 32'(intid_q), 30);
    chk(isr_q == 32'h4010_0000, "R7 isr unchanged", isr_q, 32'h4010_0000);
    do_rfe();
    do_eval(32'h0000_0100, 0, 5'd20, 0); // level 5 < 20
    chk(trap_req == 0, "R5 lower no trap", 32'(trap_req), 0);
  endtask

  task automatic t_out_of_range();
    do_rfe();
    do_eval(32'h0008_0008, 32'h8000_0020, 5'd0, 0);  // sw 3,19 ext 5,31
    chk(trap_req == 0, "R4 stray bits no trap", 32'(trap_req), 0);
    chk(isr_q == 32'h4010_0000, "R4 stray bits no summary", isr_q, 32'h4010_0000);
  endtask

  task automatic t_sw_top();
    do_rfe();
    do_eval(32'h0004_0010, 0, 5'd14, 0);  // bit 18 -> 15
    chk(trap_req == 1, "R1 level15 trap", 32'(trap_req), 1);
    chk(intid_q == 5'd15, "R1 level15", 32'(intid_q), 15);
  endtask

  task automatic t_async();
    do_rfe();
    do_eval(0, 0, 5'd0, 4'h2);
    chk(async_err == 1, "R9 err", 32'(async_err), 1);
    @(negedge clk);
    chk(async_err == 0, "R9 err pulse", 32'(async_err), 0);
  endtask

  task automatic t_rfe_same_cycle();
    // disarmed now; rfe and eval together: eval ignored, armed afterwards
    @(negedge clk);
    sw_req = 32'h0000_0020; ext_irq = 0; cur_ipl = 0; ast_req = 0;
    eval = 1'b1; rfe = 1'b1;
    @(negedge clk);
    rfe = 1'b0;
    chk(trap_req == 0, "R8 disarmed with rfe", 32'(trap_req), 0);
    @(negedge clk);
    eval = 1'b0;
    chk(trap_req == 1, "R8 rearmed by rfe", 32'(trap_req), 1);
    chk(intid_q == 5'd2, "R1 level2", 32'(intid_q), 2);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sw_req = 0; ext_irq = 0; cur_ipl = 0; ast_req = 0; eval = 0; rfe = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_sw_only();
    t_disarmed();
    t_ext_override();
    t_ext_highest();
    t_equal_ipl();
    t_out_of_range();
    t_sw_top();
    t_async();
    t_rfe_same_cycle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule